// File: doc/BRIEF.md
# Multiplexer-Tree Thermometer-to-Binary Decoder

This block turns the thermometer word produced by the comparator bank of a flash converter into an unsigned binary code. It uses nothing but a tree of 2:1 multiplexers. The middle comparator bit gives the most significant output bit, and it also steers which half of the word goes on to the next level. Each later level repeats the same split on the half it receives and yields one more output bit. For an N-bit result the tree therefore has N levels, and the signal passes through about N multiplexers.

The decoded value can leave the block directly or through one register stage. A parameter chooses between the two. The register is clocked on the rising edge and is cleared by a synchronous active-low reset. The block does not correct bubbles. When the input is not a clean thermometer word, the result follows only the bits that lie on the selected path.

Top module: `therm_mux_decoder`

## Requirements
- R1: The input `therm_i` is 2^OUT_W-1 bits wide. Bit k is 1 when the sampled level lies above threshold k+1, with bit 0 being the lowest comparator. The output `bin_o` is an OUT_W-bit unsigned number.
- R2: Any clean thermometer input (ones from bit 0 up to bit k-1, zeros above) decodes to k, the number of ones it holds.
- R3: An input of all zeros decodes to 0.
- R4: An input of all ones decodes to 2^OUT_W-1.
- R5: The most significant output bit equals input bit 2^(OUT_W-1)-1, the middle comparator.
- R6: At every level after the first, the bits come from the upper half of the current segment when the bit just produced is 1, and from the lower half when it is 0. The least significant bit is the one bit left after OUT_W-1 selections. For OUT_W=4: input 0x00BF decodes to 8, input 0x0037 decodes to 3, and input 0x0700 decodes to 0.
- R7: Bits that do not lie on the selected path have no effect on the output, and no bubble correction is attempted. For OUT_W=4: 0x7F76 decodes to 3 and 0x6880 decodes to 15.
- R8: With the output register enabled (REG_OUT=1), `bin_o` takes the decoded value of the input one rising clock edge after that input is applied. Between edges it holds its value.
- R9: The reset is synchronous and active low. When `rst_n` is low at a rising edge, `bin_o` becomes 0. Taking `rst_n` low between edges leaves `bin_o` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| therm_i | input | 2^OUT_W-1 | Thermometer word from the comparator bank, bit 0 lowest |
| bin_o | output | OUT_W | Binary output code |

## Verification
The behaviour that is hardest to reach from the ports is the way a bubble steers the tree. A clean sweep never shows it, because with a clean input the path bits and the count of ones always agree. The stimulus therefore uses hand-built words in which a hole below the middle bit, or set bits above a clear middle bit, push the tree into a half that a ones count would not pick. Further words fill every position off the path with the opposite value, to show that those positions have no effect.

// File: rtl/tmd_pkg.sv
// Package: shared sizing helpers for the multiplexer-tree decoder.
// Assumes: the level counts passed in are small (below 31).
package tmd_pkg;

    // Number of thermometer bits held by a segment that still has 'levels' bits to resolve.
    function automatic int unsigned seg_width(input int unsigned levels);
        return (32'd1 << levels) - 32'd1;
    endfunction

    // Index of the middle bit of a segment that still has 'levels' bits to resolve.
    function automatic int unsigned mid_index(input int unsigned levels);
        return (32'd1 << (levels - 32'd1)) - 32'd1;
    endfunction

endpackage

// File: rtl/tmd_mux2.sv
// Module: a single 2:1 multiplexer cell. This is the only logic element in the tree.
// Assumes: sel is a settled comparator-derived bit.
module tmd_mux2 (
    input  logic sel,
    input  logic in0,
    input  logic in1,
    output logic y
);

    // Pass in1 when sel is high, otherwise pass in0.
    always_comb begin
        y = sel ? in1 : in0;
    end

endmodule

// File: rtl/tmd_split_level.sv
// Module: one level of the tree. It emits the middle bit of its segment and forwards
//   either the upper or the lower half of the segment, selected by that bit.
// Assumes: SEG_W = 2^L-1 with L >= 2, so that both halves hold (SEG_W-1)/2 bits.
module tmd_split_level #(
    parameter int unsigned SEG_W = 15
) (
    input  logic [SEG_W-1:0]         seg_i,
    output logic                     bit_o,
    output logic [(SEG_W-1)/2-1:0]   half_o
);

    localparam int unsigned HALF_W = (SEG_W - 1) / 2;
    localparam int unsigned UP_LO  = HALF_W + 1;

    // Take the middle comparator of this segment as the bit for this level.
    always_comb begin
        bit_o = seg_i[HALF_W];
    end

    // One mux cell per forwarded bit: lower-half bit j or upper-half bit j.
    for (genvar j = 0; j < HALF_W; j++) begin : g_cell
        tmd_mux2 i_cell (
            .sel (bit_o),
            .in0 (seg_i[j]),
            .in1 (seg_i[UP_LO + j]),
            .y   (half_o[j])
        );
    end

    logic seg_clean;
    logic half_clean;

    // Classify the incoming segment and the forwarded half as clean thermometer words.
    always_comb begin
        seg_clean  = ((seg_i & (seg_i + 1'b1)) == '0);
        half_clean = ((half_o & (half_o + 1'b1)) == '0);
    end

    // A clean segment must give a clean half, and the half must be the chosen side.
    always_comb begin
        if (seg_clean) begin
            AST_HALF_STAYS_CLEAN: assert (half_clean); // R6
        end
        if (seg_clean && !bit_o) begin
            AST_UPPER_EMPTY_WHEN_LOW: assert (seg_i[SEG_W-1:UP_LO] == '0); // R2
        end
    end

endmodule

// File: rtl/tmd_out_stage.sv
// Module: optional output register. With USE_REG=1 the code is captured on the rising
//   edge and cleared by a synchronous active-low reset; with USE_REG=0 it is a plain wire.
// Assumes: d_i settles within one clock period when the register is used.
module tmd_out_stage #(
    parameter int unsigned W       = 4,
    parameter bit          USE_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    if (USE_REG) begin : g_reg
        logic [W-1:0] q_r;

        // Capture the decoded code each edge, or clear it while reset is low.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_r <= '0;
            end else begin
                q_r <= d_i;
            end
        end

        assign q_o = q_r;

        AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> q_o == '0); // R9
        AST_ONE_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> q_o == $past(d_i)); // R8
    end else begin : g_wire
        assign q_o = d_i;
    end

endmodule

// File: rtl/therm_mux_decoder.sv
// Module: thermometer-to-binary decoder built as a 2:1 multiplexer tree, one level per
//   output bit, with an optional output register.
// Assumes: OUT_W >= 1; bubbles are not corrected, so the result follows the path bits only.
module therm_mux_decoder #(
    parameter int unsigned OUT_W   = 4,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [tmd_pkg::seg_width(OUT_W)-1:0]  therm_i,
    output logic [OUT_W-1:0]                      bin_o
);

    localparam int unsigned TW  = tmd_pkg::seg_width(OUT_W);
    localparam int unsigned MID = tmd_pkg::mid_index(OUT_W);

    logic [OUT_W-1:0] dec;

    if (OUT_W == 1) begin : g_single
        // A one-bit result is the single comparator itself.
        assign dec = therm_i;
    end else begin : g_tree
        for (genvar i = 0; i < OUT_W - 1; i++) begin : g_lvl
            localparam int unsigned SW = tmd_pkg::seg_width(OUT_W - i);
            localparam int unsigned HW = (SW - 1) / 2;
            logic [SW-1:0] seg_in;
            logic [HW-1:0] half_sel;

            if (i == 0) begin : g_first
                assign seg_in = therm_i;
            end else begin : g_next
                assign seg_in = g_lvl[i-1].half_sel;
            end

            tmd_split_level #(.SEG_W(SW)) i_level (
                .seg_i  (seg_in),
                .bit_o  (dec[OUT_W-1-i]),
                .half_o (half_sel)
            );
        end

        // The last remaining bit after all selections is the least significant bit.
        assign dec[0] = g_lvl[OUT_W-2].half_sel[0];
    end

    tmd_out_stage #(.W(OUT_W), .USE_REG(REG_OUT)) i_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dec),
        .q_o   (bin_o)
    );

    logic in_clean;

    // Flag inputs that form a clean thermometer word.
    always_comb begin
        in_clean = ((therm_i & (therm_i + 1'b1)) == '0);
    end

    // Cross-check the tree against an independent ones count and the end points.
    always_comb begin
        if (in_clean) begin
            AST_CLEAN_EQUALS_COUNT: assert (dec == OUT_W'($countones(therm_i))); // R2
        end
        if (therm_i == '0) begin
            AST_ZERO_IN_ZERO_OUT: assert (dec == '0); // R3
        end
        if (therm_i == {TW{1'b1}}) begin
            AST_FULL_IN_FULL_OUT: assert (dec == {OUT_W{1'b1}}); // R4
        end
    end

    if (REG_OUT) begin : g_chk_reg
        AST_MSB_FROM_MIDDLE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> bin_o[OUT_W-1] == $past(therm_i[MID])); // R5
    end

endmodule

// File: tb/test_therm_mux_decoder.sv
`timescale 1ns/1ps
module test_therm_mux_decoder;

    localparam int unsigned N  = 4;
    localparam int unsigned TW = (1 << N) - 1;
    localparam time         HALF_P = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] therm = '0;
    logic [N-1:0]  bin;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    therm_mux_decoder #(.OUT_W(N), .REG_OUT(1'b1)) i_therm_mux_decoder (
        .clk     (clk),
        .rst_n   (rst_n),
        .therm_i (therm),
        .bin_o   (bin)
    );

    always #(HALF_P) clk = ~clk;

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (therm=0x%04h)", req, act, exp, therm);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic apply_and_check(input string req, input logic [TW-1:0] t, input logic [N-1:0] exp);
        @(negedge clk);
        therm = t;
        @(negedge clk);
        check(req, bin, exp);
    endtask

    task automatic t_reset_state();
        check("R9 reset state", bin, '0);
    endtask

    task automatic t_clean_sweep();
        for (int k = 0; k <= TW; k++) begin
            apply_and_check("R2 clean sweep", TW'((32'd1 << k) - 1), N'(k));
        end
    endtask

    task automatic t_end_points();
        apply_and_check("R3 all zeros", '0, '0);
        apply_and_check("R4 all ones", {TW{1'b1}}, {N{1'b1}});
        apply_and_check("R1 one comparator set", 15'h0001, 4'd1);
    endtask

    task automatic t_msb_middle();
        apply_and_check("R5 middle bit alone", 15'h0080, 4'd8);
        apply_and_check("R5 all but middle", 15'h7F7F, 4'd7);
    endtask

    task automatic t_path_select();
        apply_and_check("R6 upper half chosen", 15'h00BF, 4'd8);
        apply_and_check("R6 lower half chosen", 15'h0037, 4'd3);
        apply_and_check("R6 upper bits ignored", 15'h0700, 4'd0);
    endtask

    task automatic t_off_path();
        apply_and_check("R7 off-path set", 15'h7F76, 4'd3);
        apply_and_check("R7 off-path clear", 15'h6880, 4'd15);
    endtask

    task automatic t_latency();
        apply_and_check("R8 preload", 15'h7FFF, 4'd15);
        @(negedge clk);
        therm = 15'h0007;
        #(HALF_P / 2);
        check("R8 holds before edge", bin, 4'd15);
        @(negedge clk);
        check("R8 updates after edge", bin, 4'd3);
    endtask

    task automatic t_sync_reset();
        apply_and_check("R9 preload", 15'h7FFF, 4'd15);
        @(negedge clk);
        rst_n = 1'b0;
        #(HALF_P / 2);
        check("R9 no async clear", bin, 4'd15);
        @(negedge clk);
        check("R9 cleared at edge", bin, 4'd0);
        @(negedge clk);
        check("R9 held in reset", bin, 4'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 resumes after release", bin, 4'd15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_clean_sweep();
        t_end_points();
        t_msb_middle();
        t_path_select();
        t_off_path();
        t_latency();
        t_sync_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(HALF_P * 2 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule